// File: doc/BRIEF.md
# Multi-Precision Multiply-Accumulate Unit

This unit speeds up big-number arithmetic on a 64-bit datapath. It keeps three hidden multiplier words (M0, M1, M2) and three hidden carry words (P0, P1, P2) between operations. A caller loads a long multiplier once and then streams 64-bit operands through it. The high words of each product stay in the carry words and are folded into the next operation, so long products chain with no software carry handling.

An operation starts with a one-cycle `start` together with an operation code, a register index and two 64-bit operands `a` and `b`. Only one 64x64 unsigned multiplier exists. The three-word operation uses it once per multiplier word, on consecutive cycles. The unit raises `busy` from the cycle after it accepts an operation until its one-cycle `done` pulse. The 64-bit `result` is valid while `done` is high.

Top module: `mpmac_unit`

## Requirements
- R1: After reset all six hidden words are zero, `busy` and `done` are low and `result` is zero.
- R2: Operation code 0 (load multiplier) writes `a` into the multiplier word chosen by `sel` (0, 1 or 2) and sets P0, P1 and P2 to zero.
- R3: Operation code 1 (load carry) writes `a` into the carry word chosen by `sel` and leaves every other hidden word unchanged.
- R4: Operation code 2 (single-word accumulate) forms the 128-bit value M0*a + b + P0, returns its low 64 bits and places its high 64 bits in P0.
- R5: Operation code 3 (three-word accumulate) forms the 256-bit value {M2,M1,M0}*a + b + {P2,P1,P0}, returns bits 63:0 and places bits 127:64, 191:128 and 255:192 in P0, P1 and P2.
- R6: Operation code 4 (chained multiply) returns the low 64 bits of M0*a + b + P0, writes that value into M0 and sets P0, P1 and P2 to zero.
- R7: All products are unsigned, and carries out of every partial sum reach the highest word, including when every operand and hidden word is all ones.
- R8: `done` is high for exactly one cycle and `busy` is high throughout. `done` rises 1 cycle after the accepting clock edge for loads and unused codes, 2 cycles after it for codes 2 and 4, and 4 cycles after it for code 3.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the result in flight or any hidden word.
- R10: Operation codes 5 to 7, and loads with `sel` equal to 3, complete with a zero result and change no hidden word. Loads also return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when the unit is idle |
| op | input | 3 | Operation code |
| sel | input | 2 | Hidden-word index for the load operations |
| a | input | 64 | Multiplicand, or the value to load |
| b | input | 64 | Addend |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Returned word, valid while done is high |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse inside `busy`, and that a load finishes on the next cycle while a multiply first enters its step sequence. They also check that no hidden word moves while busy except at the commit, that a multiplier load empties the carry words, and that a chained commit moves the sum into M0 and clears the carries. Only the bench scenarios can show that the returned words and carries match a full-width reference computed in one expression. The same holds for carries reaching the top word with all-ones operands, exact latencies per operation, and state that survives from one operation to the next.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_M  = 3'd0,
    OP_LOAD_P  = 3'd1,
    OP_MAC_ONE = 3'd2,
    OP_MAC_ALL = 3'd3,
    OP_CHAIN   = 3'd4
  } mac_op_e;

  // Operations that use the multiplier and take the step sequence.
  function automatic logic uses_mul(input logic [2:0] code);
    return (code == OP_MAC_ONE) || (code == OP_MAC_ALL) || (code == OP_CHAIN);
  endfunction

endpackage

// File: rtl/mpmac_ctrl.sv
module mpmac_ctrl
  import mpmac_pkg::*;
#(
  parameter int unsigned NWORD = 3,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  output logic             busy,
  output logic             done,
  output logic             launch,
  output logic             step_en,
  output logic             last_step,
  output logic [IDX_W-1:0] step_idx,
  output logic [2:0]       op_q
);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_FIN} ctrl_st_e;

  ctrl_st_e         state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] final_idx;

  assign launch    = start && (state == S_IDLE);
  assign final_idx = (op_q == OP_MAC_ALL) ? IDX_W'(NWORD - 1) : '0;
  assign step_en   = (state == S_MUL);
  assign last_step = step_en && (cnt == final_idx);
  assign step_idx  = cnt;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      op_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          op_q  <= op;
          cnt   <= '0;
          state <= uses_mul(op) ? S_MUL : S_FIN;
        end
        S_MUL: begin
          if (last_step) state <= S_FIN;
          else           cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R8
  load_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !uses_mul(op)) |=> done);
  // R8
  mul_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && uses_mul(op)) |=> (step_en && !done));

endmodule

// File: rtl/mpmac_state.sv
module mpmac_state
  import mpmac_pkg::*;
#(
  parameter int unsigned WORD  = 64,
  parameter int unsigned NWORD = 3,
  localparam int unsigned SEL_W = (NWORD > 1) ? $clog2(NWORD + 1) : 1,
  localparam int unsigned ACC_W = (NWORD + 1) * WORD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [2:0]                  op,
  input  logic [SEL_W-1:0]            sel,
  input  logic [WORD-1:0]             a,
  input  logic                        busy,
  input  logic                        last_step,
  input  logic [2:0]                  op_q,
  input  logic [ACC_W-1:0]            acc_next,
  output logic [NWORD-1:0][WORD-1:0]  m_q,
  output logic [NWORD-1:0][WORD-1:0]  p_q
);

  logic sel_ok;
  assign sel_ok = (32'(sel) < NWORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      p_q <= '0;
    end else if (launch) begin
      if (op == OP_LOAD_M && sel_ok) begin
        m_q[sel] <= a;
        p_q      <= '0;
      end else if (op == OP_LOAD_P && sel_ok) begin
        p_q[sel] <= a;
      end
    end else if (last_step) begin
      case (op_q)
        OP_MAC_ONE: p_q[0] <= acc_next[2*WORD-1:WORD];
        OP_MAC_ALL: for (int k = 0; k < NWORD; k++)
                      p_q[k] <= acc_next[(k+1)*WORD +: WORD];
        OP_CHAIN: begin
          m_q[0] <= acc_next[WORD-1:0];
          p_q    <= '0;
        end
        default: ;
      endcase
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> ($stable(m_q) && $stable(p_q)));
  // R2
  ldm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && op == OP_LOAD_M && sel_ok) |=> (p_q == '0));
  // R3
  ldp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && op == OP_LOAD_P) |=> $stable(m_q));
  // R6
  chain_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && op_q == OP_CHAIN) |=>
      (p_q == '0 && m_q[0] == $past(acc_next[WORD-1:0])));

endmodule

// File: rtl/mpmac_accum.sv
module mpmac_accum
  import mpmac_pkg::*;
#(
  parameter int unsigned WORD  = 64,
  parameter int unsigned NWORD = 3,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int unsigned ACC_W = (NWORD + 1) * WORD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [2:0]                  op,
  input  logic [WORD-1:0]             a,
  input  logic [WORD-1:0]             b,
  input  logic [NWORD-1:0][WORD-1:0]  m_q,
  input  logic [NWORD-1:0][WORD-1:0]  p_q,
  input  logic                        step_en,
  input  logic                        last_step,
  input  logic [IDX_W-1:0]            step_idx,
  input  logic [2:0]                  op_q,
  output logic [ACC_W-1:0]            acc_next,
  output logic [WORD-1:0]             result
);

  // Starting sum: addend plus the carry words the operation consumes.
  function automatic logic [ACC_W-1:0] seed_sum(
    input logic [NWORD-1:0][WORD-1:0] pw,
    input logic [WORD-1:0]            addend,
    input logic                       all_words);
    logic [ACC_W-1:0] s;
    s = ACC_W'(addend);
    for (int k = 0; k < NWORD; k++)
      if (all_words || k == 0) s = s + (ACC_W'(pw[k]) << (WORD * k));
    return s;
  endfunction

  // One 64x64 unsigned product, placed at word position idx.
  function automatic logic [ACC_W-1:0] placed_product(
    input logic [WORD-1:0] mw,
    input logic [WORD-1:0] av,
    input int              idx);
    logic [2*WORD-1:0] pr;
    pr = (2*WORD)'(mw) * (2*WORD)'(av);
    return ACC_W'(pr) << (WORD * idx);
  endfunction

  logic [ACC_W-1:0] acc;
  logic [WORD-1:0]  a_q;
  logic [WORD-1:0]  m_cur;

  assign m_cur    = m_q[step_idx];
  assign acc_next = acc + placed_product(m_cur, a_q, int'(step_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      a_q    <= '0;
      result <= '0;
    end else if (launch) begin
      acc <= seed_sum(p_q, b, op == OP_MAC_ALL);
      a_q <= a;
      if (!uses_mul(op)) result <= '0;
    end else if (step_en) begin
      acc <= acc_next;
      if (last_step) result <= acc_next[WORD-1:0];
    end
  end

  // R4
  mac_one_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && op_q == OP_MAC_ONE) |-> (acc_next[ACC_W-1:2*WORD] == '0));
  // R10
  load_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !uses_mul(op)) |=> (result == '0));

endmodule

// File: rtl/mpmac_unit.sv
module mpmac_unit
  import mpmac_pkg::*;
#(
  parameter int unsigned WORD  = 64,
  parameter int unsigned NWORD = 3,
  localparam int unsigned SEL_W = (NWORD > 1) ? $clog2(NWORD + 1) : 1,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int unsigned ACC_W = (NWORD + 1) * WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [SEL_W-1:0] sel,
  input  logic [WORD-1:0]  a,
  input  logic [WORD-1:0]  b,
  output logic             busy,
  output logic             done,
  output logic [WORD-1:0]  result
);

  logic                       launch;
  logic                       step_en;
  logic                       last_step;
  logic [IDX_W-1:0]           step_idx;
  logic [2:0]                 op_q;
  logic [ACC_W-1:0]           acc_next;
  logic [NWORD-1:0][WORD-1:0] m_q;
  logic [NWORD-1:0][WORD-1:0] p_q;

  mpmac_ctrl #(.NWORD(NWORD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .busy(busy), .done(done), .launch(launch), .step_en(step_en),
    .last_step(last_step), .step_idx(step_idx), .op_q(op_q)
  );

  mpmac_state #(.WORD(WORD), .NWORD(NWORD)) u_state (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .sel(sel), .a(a),
    .busy(busy), .last_step(last_step), .op_q(op_q), .acc_next(acc_next),
    .m_q(m_q), .p_q(p_q)
  );

  mpmac_accum #(.WORD(WORD), .NWORD(NWORD)) u_accum (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .a(a), .b(b),
    .m_q(m_q), .p_q(p_q), .step_en(step_en), .last_step(last_step),
    .step_idx(step_idx), .op_q(op_q), .acc_next(acc_next), .result(result)
  );

endmodule

// File: tb/mpmac_unit_test.sv
`timescale 1ns/1ps
module mpmac_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  sel = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        busy, done;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [63:0] mm [3];
  logic [63:0] pp [3];
  logic [63:0] rng = 64'h9e37_79b9_7f4a_7c15;

  always #2 clk = ~clk;

  mpmac_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sel(sel),
    .a(a), .b(b), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // Launch one operation; model it with full-width arithmetic; check result,
  // latency and the return to idle. intrude pulses a load while busy.
  task automatic do_op(input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] av, input logic [63:0] bv,
                       input string tag, input bit intrude = 0);
    logic [63:0]  exp_res;
    int           exp_lat;
    int           lat;
    logic [127:0] w1;
    logic [255:0] w3;
    exp_res = '0;
    exp_lat = 1;
    case (o)
      3'd0: if (s < 3) begin
        mm[s] = av; pp[0] = '0; pp[1] = '0; pp[2] = '0;
      end
      3'd1: if (s < 3) pp[s] = av;
      3'd2: begin
        w1 = {64'b0, mm[0]} * {64'b0, av} + {64'b0, bv} + {64'b0, pp[0]};
        exp_res = w1[63:0]; pp[0] = w1[127:64]; exp_lat = 2;
      end
      3'd3: begin
        w3 = {64'b0, mm[2], mm[1], mm[0]} * {192'b0, av} + {192'b0, bv}
           + {64'b0, pp[2], pp[1], pp[0]};
        exp_res = w3[63:0];
        pp[0] = w3[127:64]; pp[1] = w3[191:128]; pp[2] = w3[255:192];
        exp_lat = 4;
      end
      3'd4: begin
        exp_res = mm[0] * av + bv + pp[0];
        mm[0] = exp_res; pp[0] = '0; pp[1] = '0; pp[2] = '0;
        exp_lat = 2;
      end
      default: ;
    endcase
    @(negedge clk);
    start = 1'b1; op = o; sel = s; a = av; b = bv;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (intrude && !done) begin
      start = 1'b1; op = 3'd0; sel = 2'd0; a = '1; b = '1;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    chk(done === 1'b1, {tag, " R8 done seen"}, 64'(done), 64'd1);
    chk(busy === 1'b1, {tag, " R8 busy with done"}, 64'(busy), 64'd1);
    chk(lat == exp_lat, {tag, " R8 latency"}, 64'(lat), 64'(exp_lat));
    chk(result === exp_res, {tag, " result"}, result, exp_res);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R8 back to idle"},
        {62'b0, busy, done}, 64'd0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {62'b0, busy, done}, 64'd0);
    chk(result === 64'd0, "R1 reset result", result, 64'd0);
    do_op(3'd3, 2'd0, 64'h1234_5678_9abc_def0, 64'd77, "R1 zero state");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R1 zero carries");
  endtask

  task automatic t_load_mult();
    do_op(3'd1, 2'd0, 64'h55, 64'd0, "R3 load P0");
    do_op(3'd1, 2'd2, 64'h77, 64'd0, "R3 load P2");
    do_op(3'd0, 2'd1, 64'd3, 64'd0, "R2 load M1");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R2 carries cleared");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R2 carries cleared 2");
    do_op(3'd0, 2'd0, 64'd5, 64'd0, "R2 load M0");
    do_op(3'd0, 2'd2, 64'd7, 64'd0, "R2 load M2");
  endtask

  task automatic t_load_carry();
    do_op(3'd1, 2'd1, 64'hdead_beef, 64'd0, "R3 load P1");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R3 read P0");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R3 read P1");
    do_op(3'd2, 2'd0, 64'd2, 64'd1, "R3 M0 kept");
  endtask

  task automatic t_mac_one();
    do_op(3'd0, 2'd0, 64'hffff_0000_ffff_0000, 64'd0, "R4 setup");
    do_op(3'd2, 2'd0, 64'h1_0000_0001, 64'd9, "R4 first");
    do_op(3'd2, 2'd0, 64'h8000_0000_0000_0000, 64'h1111, "R4 carry in");
    do_op(3'd2, 2'd0, 64'd0, 64'd0, "R4 drain P0");
  endtask

  task automatic t_mac_all();
    do_op(3'd0, 2'd0, 64'h0123_4567_89ab_cdef, 64'd0, "R5 setup 0");
    do_op(3'd0, 2'd1, 64'hfedc_ba98_7654_3210, 64'd0, "R5 setup 1");
    do_op(3'd0, 2'd2, 64'h0f0f_f0f0_1234_4321, 64'd0, "R5 setup 2");
    do_op(3'd3, 2'd0, 64'hcafe_f00d_1357_9bdf, 64'd42, "R5 first word");
    do_op(3'd3, 2'd0, 64'h2468_ace0_1122_3344, 64'h5, "R5 chained word");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R5 read P0");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R5 read P1");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R5 read P2");
  endtask

  task automatic t_chain();
    do_op(3'd1, 2'd0, 64'h100, 64'd0, "R6 P0 preset");
    do_op(3'd1, 2'd2, 64'h200, 64'd0, "R6 P2 preset");
    do_op(3'd4, 2'd0, 64'h1_0000_0003, 64'h10, "R6 chain");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R6 carries zero");
    do_op(3'd2, 2'd0, 64'd3, 64'd0, "R6 new M0 used");
  endtask

  task automatic t_carry();
    for (int k = 0; k < 3; k++) do_op(3'd0, 2'(k), '1, 64'd0, "R7 ones M");
    for (int k = 0; k < 3; k++) do_op(3'd1, 2'(k), '1, 64'd0, "R7 ones P");
    do_op(3'd3, 2'd0, '1, '1, "R7 max three-word");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R7 top word P0");
    do_op(3'd3, 2'd0, 64'd0, 64'd0, "R7 top word P1");
    do_op(3'd1, 2'd0, '1, 64'd0, "R7 ones P0");
    do_op(3'd2, 2'd0, '1, '1, "R7 max single-word");
    do_op(3'd2, 2'd0, 64'd0, 64'd0, "R7 single high");
  endtask

  task automatic t_busy();
    do_op(3'd0, 2'd0, 64'h1234, 64'd0, "R9 setup");
    do_op(3'd3, 2'd0, 64'h55aa, 64'd3, "R9 intrude three-word", 1'b1);
    do_op(3'd2, 2'd0, 64'h2, 64'd0, "R9 intrude single", 1'b1);
    do_op(3'd2, 2'd0, 64'd1, 64'd0, "R9 M0 unchanged");
  endtask

  task automatic t_unused();
    do_op(3'd1, 2'd0, 64'h99, 64'd0, "R10 preset P0");
    do_op(3'd5, 2'd0, 64'hffff, 64'hffff, "R10 code 5");
    do_op(3'd7, 2'd1, 64'hffff, 64'hffff, "R10 code 7");
    do_op(3'd0, 2'd3, 64'hbad, 64'd0, "R10 load M sel 3");
    do_op(3'd1, 2'd3, 64'hbad, 64'd0, "R10 load P sel 3");
    do_op(3'd2, 2'd0, 64'd1, 64'd0, "R10 state kept");
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 30; i++) begin
      logic [63:0] r1, r2, r3;
      r1 = next_rand(); r2 = next_rand(); r3 = next_rand();
      case (r3[2:0])
        3'd0, 3'd1: do_op(3'd0, 2'(r3[5:4] % 3), r1, r2, "R2 mixed");
        3'd2:       do_op(3'd1, 2'(r3[5:4] % 3), r1, r2, "R3 mixed");
        3'd3, 3'd4: do_op(3'd3, 2'd0, r1, r2, "R5 mixed");
        3'd5, 3'd6: do_op(3'd2, 2'd0, r1, r2, "R4 mixed");
        default:    do_op(3'd4, 2'd0, r1, r2, "R6 mixed");
      endcase
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin mm[k] = '0; pp[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_mult();
    t_load_carry();
    t_mac_one();
    t_mac_all();
    t_chain();
    t_carry();
    t_busy();
    t_unused();
    t_mixed();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule